// File: doc/BRIEF.md
# ONFI Asynchronous Timing Mode Negotiator

This block picks the fastest asynchronous timing mode that a NAND device reports and, when possible, switches the controller into extended-data-out (EDO) reads. It supports mode 5 and mode 4. After a start pulse it looks at the device's supported-mode mask. It then asks a command engine to write the chosen mode into the device's timing-mode feature, and asks the engine to read that feature back. EDO and the faster interface clock are enabled only when the value read back matches the mode that was written.

The NAND pin signalling is not part of this block. It talks to an abstract command engine through a request/acknowledge handshake. The acknowledge carries an error flag and the first returned parameter byte. If the exchange fails, or the value read back differs, the block reports an error and leaves the controller at normal timing with the normal clock.

Top module: `onfi_mode_negotiator`

## Requirements
- R1: Mode choice uses the supported-mode mask, where bit n means mode n. Mode 5 is chosen if bit 5 is set. Otherwise mode 4 is chosen if bit 4 is set.
- R2: If neither bit 4 nor bit 5 is set, `done_o` pulses for one cycle in the cycle after start. No request is issued, the chip is not selected, `err_o` stays 0 and `edo_en_o` stays 0.
- R3: The first request is a write (`cmd_is_get_o`=0) to feature address 0x01. Parameter byte 0 (bits 7:0) equals the chosen mode, and bits 31:8 are zero.
- R4: `chip_sel_o` rises in the cycle after an accepted start and stays high for the whole exchange. It is low in the cycle where `done_o` pulses, on success and on failure alike.
- R5: A write acknowledged without error is followed in the next cycle by a read request (`cmd_is_get_o`=1) to the same address.
- R6: On a matching read-back the block sets `edo_en_o`, loads `mode_o` with the mode and pulses `done_o` with `err_o`=0. It drives `clk_sel_o` to 2'b10 (100 MHz) for mode 5 or to 2'b01 (80 MHz) for mode 4.
- R7: If the byte read back differs from the mode, `done_o` and `err_o` pulse together. `edo_en_o` stays 0, `clk_sel_o` stays 2'b00 (normal) and `mode_o` stays 0.
- R8: An acknowledge with `cmd_err_i` high counts as a failure, handled as in R7. An error on the write ends the exchange without issuing a read.
- R9: An accepted start clears `edo_en_o`, `clk_sel_o` and `mode_o` in the next cycle.
- R10: A start pulse that arrives while an exchange is running is ignored.
- R11: `cmd_req_o`, `cmd_is_get_o` and `cmd_param_o` stay unchanged until `cmd_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| mode_support_i | input | 6 | Supported-mode mask, bit n = mode n |
| cmd_req_o | output | 1 | Command request to the engine |
| cmd_is_get_o | output | 1 | 0 = write feature, 1 = read feature |
| cmd_addr_o | output | 8 | Feature address (0x01) |
| cmd_param_o | output | 32 | Four parameter bytes, byte 0 in bits 7:0 |
| cmd_ack_i | input | 1 | Engine acknowledge, one cycle |
| cmd_err_i | input | 1 | Engine error, valid with acknowledge |
| cmd_rdata_i | input | 8 | First returned parameter byte, valid with acknowledge |
| chip_sel_o | output | 1 | Chip select for the exchange |
| mode_o | output | 3 | Enabled mode, 0 when none |
| clk_sel_o | output | 2 | 00 normal, 01 80 MHz, 10 100 MHz |
| edo_en_o | output | 1 | EDO timing enabled |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Failure pulse, with done |

## Verification
The assertions check several invariants on every cycle. A request is always made with the chip selected and to the fixed address, with only byte 0 non-zero. A request holds until it is acknowledged. A clean write acknowledge leads to a read, and completion deselects the chip. EDO never appears without a fast clock select, and an error never comes with EDO. Only the bench's scenarios show that the mode follows the priority rule, that a wrong read-back byte or an engine error falls back to normal timing, that a start during a busy exchange is dropped, and that a new start clears the previous result.

// File: rtl/onfi_neg_pkg.sv
package onfi_neg_pkg;
    localparam int FAST_MODE = 5;
    localparam int SLOW_MODE = 4;
    localparam int SUP_W     = FAST_MODE + 1;
    localparam int MODE_W    = 3;

    localparam logic [1:0] CLK_NORM = 2'b00;
    localparam logic [1:0] CLK_80   = 2'b01;
    localparam logic [1:0] CLK_100  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SET  = 2'd1,
        ST_GET  = 2'd2
    } neg_st_e;

    typedef struct packed {
        neg_st_e           st;
        logic              cs;
        logic              req;
        logic              is_get;
        logic [MODE_W-1:0] cand;
        logic [MODE_W-1:0] mode;
        logic              edo;
        logic [1:0]        clk;
        logic              done;
        logic              err;
    } neg_regs_t;
endpackage

// File: rtl/onfi_mode_pick.sv
module onfi_mode_pick
    import onfi_neg_pkg::*;
(
    input  logic [SUP_W-1:0]  mask_i,
    output logic              found_o,
    output logic [MODE_W-1:0] mode_o
);
    logic [MODE_W-1:0] top_bit;

    // highest set bit wins; it is usable only at or above the slowest EDO mode
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < SUP_W; i++) begin
            if (mask_i[i]) top_bit = MODE_W'(i);
        end
    end

    assign found_o = (top_bit >= MODE_W'(SLOW_MODE));
    assign mode_o  = found_o ? top_bit : '0;
endmodule

// File: rtl/onfi_clk_map.sv
module onfi_clk_map
    import onfi_neg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output logic [1:0]        sel_o
);
    assign sel_o = (mode_i == MODE_W'(FAST_MODE)) ? CLK_100 : CLK_80;
endmodule

// File: rtl/onfi_param_pack.sv
module onfi_param_pack
    import onfi_neg_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic [MODE_W-1:0]   mode_i,
    output logic [8*NBYTES-1:0] param_o
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        if (b == 0) begin : g_first
            assign param_o[7:0] = {{(8-MODE_W){1'b0}}, mode_i};
        end else begin : g_zero
            assign param_o[8*b+7:8*b] = 8'h00;
        end
    end
endmodule

// File: rtl/onfi_mode_negotiator.sv
module onfi_mode_negotiator
    import onfi_neg_pkg::*;
#(
    parameter logic [7:0] FEAT_ADDR   = 8'h01,
    parameter int         PARAM_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [SUP_W-1:0]         mode_support_i,
    output logic                     cmd_req_o,
    output logic                     cmd_is_get_o,
    output logic [7:0]               cmd_addr_o,
    output logic [8*PARAM_BYTES-1:0] cmd_param_o,
    input  logic                     cmd_ack_i,
    input  logic                     cmd_err_i,
    input  logic [7:0]               cmd_rdata_i,
    output logic                     chip_sel_o,
    output logic [MODE_W-1:0]        mode_o,
    output logic [1:0]               clk_sel_o,
    output logic                     edo_en_o,
    output logic                     done_o,
    output logic                     err_o
);
    neg_regs_t         r_q, r_d;
    logic              pick_found;
    logic [MODE_W-1:0] pick_mode;
    logic [1:0]        fast_sel;
    logic              readback_ok;

    onfi_mode_pick u_pick (
        .mask_i  (mode_support_i),
        .found_o (pick_found),
        .mode_o  (pick_mode)
    );

    onfi_clk_map u_clk (
        .mode_i (r_q.cand),
        .sel_o  (fast_sel)
    );

    onfi_param_pack #(.NBYTES(PARAM_BYTES)) u_pack (
        .mode_i  (r_q.cand),
        .param_o (cmd_param_o)
    );

    assign readback_ok = !cmd_err_i &&
                         (cmd_rdata_i == {{(8-MODE_W){1'b0}}, r_q.cand});

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.edo  = 1'b0;
                    r_d.mode = '0;
                    r_d.clk  = CLK_NORM;
                    r_d.cand = pick_mode;
                    if (pick_found) begin
                        r_d.st     = ST_SET;
                        r_d.cs     = 1'b1;
                        r_d.req    = 1'b1;
                        r_d.is_get = 1'b0;
                    end else begin
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_SET: begin
                if (cmd_ack_i) begin
                    if (cmd_err_i) begin
                        r_d.st     = ST_IDLE;
                        r_d.cs     = 1'b0;
                        r_d.req    = 1'b0;
                        r_d.is_get = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.err    = 1'b1;
                    end else begin
                        r_d.st     = ST_GET;
                        r_d.is_get = 1'b1;
                    end
                end
            end
            ST_GET: begin
                if (cmd_ack_i) begin
                    r_d.st     = ST_IDLE;
                    r_d.cs     = 1'b0;
                    r_d.req    = 1'b0;
                    r_d.is_get = 1'b0;
                    r_d.done   = 1'b1;
                    if (readback_ok) begin
                        r_d.edo  = 1'b1;
                        r_d.mode = r_q.cand;
                        r_d.clk  = fast_sel;
                    end else begin
                        r_d.err  = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_req_o    = r_q.req;
    assign cmd_is_get_o = r_q.is_get;
    assign cmd_addr_o   = FEAT_ADDR;
    assign chip_sel_o   = r_q.cs;
    assign mode_o       = r_q.mode;
    assign clk_sel_o    = r_q.clk;
    assign edo_en_o     = r_q.edo;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
endmodule

// File: rtl/onfi_neg_checker.sv
module onfi_neg_checker
    import onfi_neg_pkg::*;
#(
    parameter logic [7:0] FEAT_ADDR   = 8'h01,
    parameter int         PARAM_BYTES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     cmd_req_o,
    input logic                     cmd_is_get_o,
    input logic [7:0]               cmd_addr_o,
    input logic [8*PARAM_BYTES-1:0] cmd_param_o,
    input logic                     cmd_ack_i,
    input logic                     cmd_err_i,
    input logic                     chip_sel_o,
    input logic [MODE_W-1:0]        mode_o,
    input logic [1:0]               clk_sel_o,
    input logic                     edo_en_o,
    input logic                     done_o,
    input logic                     err_o
);
    a_r3_request_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |-> (cmd_addr_o == FEAT_ADDR) &&
                      (cmd_param_o[8*PARAM_BYTES-1:8] == '0) &&
                      ((cmd_param_o[7:0] == 8'd5) || (cmd_param_o[7:0] == 8'd4)));

    a_r4_select_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |-> chip_sel_o);

    a_r4_deselect_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !chip_sel_o && !cmd_req_o);

    a_r5_read_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && cmd_ack_i && !cmd_err_i && !cmd_is_get_o)
        |=> cmd_req_o && cmd_is_get_o);

    a_r6_edo_has_fast_clock: assert property (@(posedge clk) disable iff (!rst_n)
        edo_en_o |-> (clk_sel_o != CLK_NORM) && (mode_o != '0));

    a_r7_error_without_edo: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o && !edo_en_o && (clk_sel_o == CLK_NORM));

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !chip_sel_o) |=> !edo_en_o && (clk_sel_o == CLK_NORM) && (mode_o == '0));

    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_ack_i) |=> cmd_req_o && $stable(cmd_is_get_o) && $stable(cmd_param_o));
endmodule

bind onfi_mode_negotiator onfi_neg_checker #(
    .FEAT_ADDR   (FEAT_ADDR),
    .PARAM_BYTES (PARAM_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_req_o    (cmd_req_o),
    .cmd_is_get_o (cmd_is_get_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_param_o  (cmd_param_o),
    .cmd_ack_i    (cmd_ack_i),
    .cmd_err_i    (cmd_err_i),
    .chip_sel_o   (chip_sel_o),
    .mode_o       (mode_o),
    .clk_sel_o    (clk_sel_o),
    .edo_en_o     (edo_en_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/sim_onfi_mode_negotiator.sv
module sim_onfi_mode_negotiator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  mode_support_i = '0;
    logic        cmd_req_o, cmd_is_get_o;
    logic [7:0]  cmd_addr_o;
    logic [31:0] cmd_param_o;
    logic        cmd_ack_i = 1'b0;
    logic        cmd_err_i = 1'b0;
    logic [7:0]  cmd_rdata_i = '0;
    logic        chip_sel_o;
    logic [2:0]  mode_o;
    logic [1:0]  clk_sel_o;
    logic        edo_en_o, done_o, err_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    onfi_mode_negotiator u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_support_i(mode_support_i),
        .cmd_req_o(cmd_req_o), .cmd_is_get_o(cmd_is_get_o), .cmd_addr_o(cmd_addr_o),
        .cmd_param_o(cmd_param_o), .cmd_ack_i(cmd_ack_i), .cmd_err_i(cmd_err_i),
        .cmd_rdata_i(cmd_rdata_i), .chip_sel_o(chip_sel_o), .mode_o(mode_o),
        .clk_sel_o(clk_sel_o), .edo_en_o(edo_en_o), .done_o(done_o), .err_o(err_o)
    );

    // behavioural reference model
    int m_phase, m_cand, m_mode, m_clk;
    bit m_cs, m_req, m_get, m_edo, m_done, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cand = 0; m_mode = 0; m_clk = 0;
            m_cs = 0; m_req = 0; m_get = 0; m_edo = 0; m_done = 0; m_err = 0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_phase == 0) begin
                if (start_i) begin
                    m_edo = 0; m_mode = 0; m_clk = 0;
                    m_cand = mode_support_i[5] ? 5 : (mode_support_i[4] ? 4 : 0);
                    if (m_cand != 0) begin
                        m_phase = 1; m_cs = 1; m_req = 1; m_get = 0;
                    end else m_done = 1;
                end
            end else if (cmd_ack_i) begin
                if (cmd_err_i || (m_phase == 2 && int'(cmd_rdata_i) != m_cand)) begin
                    m_phase = 0; m_cs = 0; m_req = 0; m_get = 0; m_done = 1; m_err = 1;
                end else if (m_phase == 1) begin
                    m_phase = 2; m_get = 1;
                end else begin
                    m_phase = 0; m_cs = 0; m_req = 0; m_get = 0; m_done = 1;
                    m_edo = 1; m_mode = m_cand; m_clk = (m_cand == 5) ? 2 : 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // per-cycle comparison against the model, sampled at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !finished) begin
            check(chip_sel_o == m_cs, "R4 chip_sel", chip_sel_o, m_cs);
            check(cmd_req_o == m_req, "R11 cmd_req", cmd_req_o, m_req);
            check(cmd_is_get_o == m_get, "R5 cmd_is_get", cmd_is_get_o, m_get);
            check(cmd_addr_o == 8'h01, "R3 cmd_addr", cmd_addr_o, 1);
            check(cmd_param_o == 32'(m_cand), "R3 cmd_param", cmd_param_o, m_cand);
            check(edo_en_o == m_edo, "R6 edo_en", edo_en_o, m_edo);
            check(int'(mode_o) == m_mode, "R1 mode", mode_o, m_mode);
            check(int'(clk_sel_o) == m_clk, "R6 clk_sel", clk_sel_o, m_clk);
            check(done_o == m_done, "R2 done", done_o, m_done);
            check(err_o == m_err, "R7 err", err_o, m_err);
        end
        if (cycles > 20000 && !finished) begin
            finished = 1;
            check(1'b0, "watchdog", cycles, 20000);
            report();
        end
    end

    // engine response: wait for a request, hold off lat cycles, acknowledge
    task automatic serve(input int lat, input bit e, input logic [7:0] rd, input bit poke);
        int n = 0;
        while (!cmd_req_o && n < 50) begin @(negedge clk); n++; end
        for (int k = 0; k < lat; k++) begin
            if (poke && k == 0) begin start_i = 1; mode_support_i = 6'b010000; end
            else start_i = 0;
            @(negedge clk);
        end
        start_i = 0;
        cmd_ack_i = 1; cmd_err_i = e; cmd_rdata_i = rd;
        @(negedge clk);
        cmd_ack_i = 0; cmd_err_i = 0; cmd_rdata_i = 8'h00;
    endtask

    task automatic run(input logic [5:0] mask, input bit has_mode,
                       input int set_lat, input bit set_err, input bit poke,
                       input int get_lat, input bit get_err, input logic [7:0] rd,
                       input bit exp_edo, input int exp_mode, input int exp_clk,
                       input bit exp_err, input string tag);
        int w = 0;
        @(negedge clk);
        start_i = 1; mode_support_i = mask;
        @(negedge clk);
        start_i = 0;
        if (has_mode) begin
            serve(set_lat, set_err, 8'h00, poke);
            if (!set_err) serve(get_lat, get_err, rd, 1'b0);
        end
        while (!done_o && w < 40) begin @(negedge clk); w++; end
        check(done_o == 1'b1, {tag, " done"}, done_o, 1);
        check(err_o == exp_err, {tag, " err"}, err_o, exp_err);
        check(edo_en_o == exp_edo, {tag, " edo"}, edo_en_o, exp_edo);
        check(int'(mode_o) == exp_mode, {tag, " mode"}, mode_o, exp_mode);
        check(int'(clk_sel_o) == exp_clk, {tag, " clk_sel"}, clk_sel_o, exp_clk);
        check(chip_sel_o == 1'b0, {tag, " deselect R4"}, chip_sel_o, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!cmd_req_o && !chip_sel_o && !edo_en_o && mode_o == 0 && clk_sel_o == 0
              && !done_o && !err_o, "reset state", {cmd_req_o, chip_sel_o, edo_en_o}, 0);
        // R1 R6: mode 5 preferred, 100 MHz
        run(6'b110000, 1, 0, 0, 0, 1, 0, 8'd5, 1, 5, 2, 0, "R1_R6 mode5");
        // R9 R2: new start with no usable mode clears the earlier result
        run(6'b001111, 0, 0, 0, 0, 0, 0, 8'd0, 0, 0, 0, 0, "R9_R2 none");
        // R1 R6: only mode 4, slow engine, 80 MHz
        run(6'b011010, 1, 3, 0, 0, 2, 0, 8'd4, 1, 4, 1, 0, "R1_R6 mode4");
        // R7: read-back mismatch
        run(6'b100000, 1, 1, 0, 0, 1, 0, 8'd4, 0, 0, 0, 1, "R7 mismatch");
        // R8: engine error on write, no read issued
        run(6'b110000, 1, 0, 1, 0, 0, 0, 8'd0, 0, 0, 0, 1, "R8 set error");
        // R8: engine error on read
        run(6'b010000, 1, 0, 0, 0, 0, 1, 8'd4, 0, 0, 0, 1, "R8 get error");
        // R10 R11: start during busy write phase is ignored; request held
        run(6'b100000, 1, 4, 0, 1, 0, 0, 8'd5, 1, 5, 2, 0, "R10_R11 busy start");
        // R2: empty mask
        run(6'b000000, 0, 0, 0, 0, 0, 0, 8'd0, 0, 0, 0, 0, "R2 empty");
        finished = 1;
        report();
    end
endmodule